// File: doc/BRIEF.md
# Receive Frame FIFO with Collision Rollback

This block sits between the byte stream of an Ethernet receive path and a reader that moves whole frames into memory. The receive side writes one byte per cycle once a frame has opened. Until the frame has gone past its early part, the bytes are held speculatively. In that early part a collision, an address rejection or a short frame can still remove the frame. The reader only sees data that can no longer be withdrawn. Each stored byte carries an end flag and an overflow flag, and the reader gets them alongside the data.

The write control is a four-state machine:

- `S_IDLE`: waits for the delimiter pulse.
- `S_WIN`: receives bytes while the frame is still inside its commit window.
- `S_STREAM`: receives bytes once the frame has been committed.
- `S_DROP`: discards the rest of a frame that overflowed.

The transitions are:

- `S_IDLE` to `S_WIN` on the delimiter.
- `S_WIN` to `S_IDLE` on collision, rejection, a runt end, a whole-frame overflow drop, or a normal end past the window.
- `S_WIN` to `S_STREAM` when the stored length reaches the threshold.
- `S_STREAM` to `S_IDLE` on the end byte.
- `S_WIN` or `S_STREAM` to `S_DROP` on an overflow that happens before the end byte.
- `S_DROP` to `S_IDLE` on the end byte.

On a rollback the write pointer returns to the frame-start pointer that was saved when the delimiter was seen. A sticky overflow flag is also driven out as an interrupt level.

Top module: `rx_frame_fifo`

## Requirements
- R1: With no frame open, bytes are ignored and only `rx_sfd` starts a frame. An `rx_sfd` pulse inside an open frame has no effect.
- R2: The commit threshold is T = max(`cfg_colwin`, 64) bytes. Start from an empty FIFO and feed a frame. After its k-th byte that is not the end byte, `rd_avail` is 1 exactly when k >= T. After a kept end byte, `rd_avail` is 1.
- R3: An `rx_collision` while fewer than T bytes of the frame are stored removes the whole frame. Once T bytes are stored, `rx_collision` is ignored and the frame is kept.
- R4: An `rx_reject` while fewer than T bytes are stored removes the whole frame. Once T bytes are stored, `rx_reject` is ignored.
- R5: A frame whose end byte (`rx_last`) arrives with fewer than T bytes stored is discarded.
- R6: A byte that arrives while the FIFO holds DEPTH entries is an overflow. If fewer than 64 bytes of the frame are stored at that point, the whole frame is discarded. This also covers frames that start while the FIFO is still full.
- R7: On an overflow with 64 or more bytes stored, the stored bytes are kept and the frame is closed. Its last stored byte is read with `rd_last`=1 and `rd_ovf`=1. Further bytes up to `rx_last` are dropped.
- R8: Any overflow sets `ovf_flag`. The flag stays set until a cycle with `ovf_clr`=1 and no new overflow. `ovf_irq` equals `ovf_flag`.
- R9: `rx_err` has no effect; a frame with errored bytes is stored as usual.
- R10: The reader reads bytes in arrival order with show-ahead data. A byte is popped when `rd_en`=1 and `rd_avail`=1. The end byte of a normally ended frame has `rd_last`=1 and `rd_ovf`=0. After reset `rd_avail`, `ovf_flag` and `ovf_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_colwin | input | 8 | Collision window in bytes; change only between frames |
| rx_sfd | input | 1 | Delimiter seen; opens a frame |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Current byte ends the frame |
| rx_collision | input | 1 | Collision seen |
| rx_reject | input | 1 | Address filter rejected the frame |
| rx_err | input | 1 | Other receive error (ignored) |
| rd_en | input | 1 | Reader pop request |
| rd_avail | output | 1 | Committed data present |
| rd_data | output | 8 | Head byte |
| rd_last | output | 1 | Head byte ends a frame |
| rd_ovf | output | 1 | Head byte ends a truncated frame |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_irq | output | 1 | Overflow interrupt level |

## Verification
The hardest case to reach is an overflow that lands exactly on one side of the 64-byte mark while the frame is still in its commit window. That state is hard to set up because the fill level must sit at the depth at the precise byte index of the frame. The bench holds the reader idle while frames are written, so the fill level follows only from the bytes it has sent. A first frame of chosen length sets up the fill, and the next frame then crosses the limit at a known stored count. Random rounds with window values above and below 64 then mix collisions, rejections and delimiter pulses inside open frames around those boundaries.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_WIN    = 2'd1,
        S_STREAM = 2'd2,
        S_DROP   = 2'd3
    } rxf_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              last;
        logic              ovf;
    } rxf_entry_t;
endpackage

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
    import rxf_pkg::*;
#(
    parameter int DEPTH    = 256,
    parameter int CW       = 8,
    parameter int KEEP_MIN = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CW-1:0]           cfg_colwin,
    input  logic                    rx_sfd,
    input  logic                    rx_valid,
    input  logic [DATA_W-1:0]       rx_data,
    input  logic                    rx_last,
    input  logic                    rx_collision,
    input  logic                    rx_reject,
    input  logic [$clog2(DEPTH):0]  rd_ptr,
    output logic                    we,
    output logic [$clog2(DEPTH)-1:0] waddr,
    output rxf_entry_t              wentry,
    output logic [$clog2(DEPTH):0]  wr_ptr,
    output logic [$clog2(DEPTH):0]  cmt_ptr,
    output logic                    ovf_evt,
    output rxf_state_t              st
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;
    localparam int LW = ((PW > CW) ? PW : CW) + 1;

    rxf_state_t          st_n;
    logic [PW-1:0]       wr_ptr_n, cmt_n, fs_ptr, fs_n;
    logic [LW-1:0]       flen, flen_n, flen_inc, thr, colw_ext;
    logic [DATA_W-1:0]   prev_byte, prev_n;
    logic [PW-1:0]       fill;
    logic                full, in_window;

    assign colw_ext  = LW'(cfg_colwin);
    assign thr       = (colw_ext > LW'(KEEP_MIN)) ? colw_ext : LW'(KEEP_MIN);
    assign fill      = wr_ptr - rd_ptr;
    assign full      = fill[AW];
    assign flen_inc  = flen + 1'b1;
    assign in_window = (st == S_WIN);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= S_IDLE;
            wr_ptr    <= '0;
            cmt_ptr   <= '0;
            fs_ptr    <= '0;
            flen      <= '0;
            prev_byte <= '0;
        end else begin
            st        <= st_n;
            wr_ptr    <= wr_ptr_n;
            cmt_ptr   <= cmt_n;
            fs_ptr    <= fs_n;
            flen      <= flen_n;
            prev_byte <= prev_n;
        end
    end

    // next state and write outputs
    always_comb begin
        st_n     = st;
        wr_ptr_n = wr_ptr;
        cmt_n    = cmt_ptr;
        fs_n     = fs_ptr;
        flen_n   = flen;
        prev_n   = prev_byte;
        we       = 1'b0;
        waddr    = wr_ptr[AW-1:0];
        wentry   = '{data: rx_data, last: rx_last, ovf: 1'b0};
        ovf_evt  = 1'b0;
        unique case (st)
            S_IDLE: begin
                if (rx_sfd) begin
                    fs_n   = wr_ptr;
                    flen_n = '0;
                    st_n   = S_WIN;
                end
            end
            S_WIN, S_STREAM: begin
                if (in_window && (rx_collision || rx_reject)) begin
                    wr_ptr_n = fs_ptr;
                    st_n     = S_IDLE;
                end else if (rx_valid) begin
                    if (full) begin
                        ovf_evt = 1'b1;
                        if (flen >= LW'(KEEP_MIN)) begin
                            we     = 1'b1;
                            waddr  = AW'(wr_ptr - 1'b1);
                            wentry = '{data: prev_byte, last: 1'b1, ovf: 1'b1};
                            cmt_n  = wr_ptr;
                        end else begin
                            wr_ptr_n = fs_ptr;
                        end
                        st_n = rx_last ? S_IDLE : S_DROP;
                    end else begin
                        we       = 1'b1;
                        wr_ptr_n = wr_ptr + 1'b1;
                        flen_n   = flen_inc;
                        prev_n   = rx_data;
                        if (rx_last) begin
                            st_n = S_IDLE;
                            if (flen_inc >= thr) cmt_n = wr_ptr + 1'b1;
                            else wr_ptr_n = fs_ptr;
                        end else if (flen_inc >= thr) begin
                            st_n  = S_STREAM;
                            cmt_n = wr_ptr;
                        end
                    end
                end
            end
            S_DROP: begin
                if (rx_valid && rx_last) st_n = S_IDLE;
            end
            default: st_n = S_IDLE;
        endcase
    end
endmodule

// File: rtl/rxf_store.sv
module rxf_store
    import rxf_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  rxf_entry_t               wentry,
    input  logic [$clog2(DEPTH):0]   cmt_ptr,
    input  logic                     rd_en,
    output logic [$clog2(DEPTH):0]   rd_ptr,
    output logic                     rd_avail,
    output rxf_entry_t               head
);
    localparam int AW = $clog2(DEPTH);

    rxf_entry_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wentry;
    end

    assign rd_avail = (rd_ptr != cmt_ptr);
    assign head     = mem[rd_ptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (!rst_n) rd_ptr <= '0;
        else if (rd_en && rd_avail) rd_ptr <= rd_ptr + 1'b1;
    end
endmodule

// File: rtl/rxf_sticky.sv
module rxf_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (set_evt) flag <= 1'b1;
        else if (clr)     flag <= 1'b0;
    end
endmodule

// File: rtl/rx_frame_fifo.sv
module rx_frame_fifo
    import rxf_pkg::*;
#(
    parameter int DEPTH    = 256,
    parameter int CW       = 8,
    parameter int KEEP_MIN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CW-1:0]     cfg_colwin,
    input  logic              rx_sfd,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_last,
    input  logic              rx_collision,
    input  logic              rx_reject,
    input  logic              rx_err,
    input  logic              rd_en,
    output logic              rd_avail,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_last,
    output logic              rd_ovf,
    input  logic              ovf_clr,
    output logic              ovf_flag,
    output logic              ovf_irq
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic          we;
    logic [AW-1:0] waddr;
    rxf_entry_t    wentry, head;
    logic [PW-1:0] wr_ptr, cmt_ptr, rd_ptr;
    logic          ovf_evt;
    rxf_state_t    st;
    logic          unused_err;

    assign unused_err = rx_err;

    rxf_ctrl #(.DEPTH(DEPTH), .CW(CW), .KEEP_MIN(KEEP_MIN)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_colwin(cfg_colwin),
        .rx_sfd(rx_sfd), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_last(rx_last), .rx_collision(rx_collision), .rx_reject(rx_reject),
        .rd_ptr(rd_ptr), .we(we), .waddr(waddr), .wentry(wentry),
        .wr_ptr(wr_ptr), .cmt_ptr(cmt_ptr), .ovf_evt(ovf_evt), .st(st)
    );

    rxf_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wentry(wentry),
        .cmt_ptr(cmt_ptr), .rd_en(rd_en), .rd_ptr(rd_ptr),
        .rd_avail(rd_avail), .head(head)
    );

    rxf_sticky u_sticky (
        .clk(clk), .rst_n(rst_n), .set_evt(ovf_evt), .clr(ovf_clr), .flag(ovf_flag)
    );

    assign rd_data = head.data;
    assign rd_last = head.last;
    assign rd_ovf  = head.ovf;
    assign ovf_irq = ovf_flag;
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker
    import rxf_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int PW    = 9
) (
    input logic          clk,
    input logic          rst_n,
    input rxf_state_t    st,
    input logic [PW-1:0] wr_ptr,
    input logic [PW-1:0] rd_ptr,
    input logic [PW-1:0] cmt_ptr,
    input logic          rd_en,
    input logic          rd_avail,
    input logic          ovf_evt,
    input logic          ovf_clr,
    input logic          ovf_flag
);
    logic [PW-1:0] fill, vis;
    assign fill = wr_ptr - rd_ptr;
    assign vis  = cmt_ptr - rd_ptr;

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= PW'(DEPTH)); // R6
    AST_COMMIT_BEHIND: assert property (@(posedge clk) disable iff (!rst_n)
        vis <= fill); // R2
    AST_VISIBLE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_avail && !rd_en |=> rd_avail); // R3
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        st == S_IDLE |=> $stable(wr_ptr)); // R1
    AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> ovf_flag); // R8
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag && !ovf_clr |=> ovf_flag); // R8
endmodule

bind rx_frame_fifo rxf_checker #(.DEPTH(DEPTH), .PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .st(st), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .cmt_ptr(cmt_ptr), .rd_en(rd_en), .rd_avail(rd_avail), .ovf_evt(ovf_evt),
    .ovf_clr(ovf_clr), .ovf_flag(ovf_flag)
);

// File: tb/rx_frame_fifo_tb.sv
`timescale 1ns/1ps
module rx_frame_fifo_tb;
    localparam int DEPTH = 256;
    localparam int MSK   = 4095;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [7:0] cfg_colwin = 8'd64;
    logic rx_sfd = 0, rx_valid = 0, rx_last = 0, rx_collision = 0, rx_reject = 0, rx_err = 0;
    logic [7:0] rx_data = 0;
    logic rd_en = 0, ovf_clr = 0;
    logic rd_avail, rd_last, rd_ovf, ovf_flag, ovf_irq;
    logic [7:0] rd_data;

    always #4 clk = ~clk;

    rx_frame_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_colwin(cfg_colwin), .rx_sfd(rx_sfd),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .rx_collision(rx_collision), .rx_reject(rx_reject), .rx_err(rx_err),
        .rd_en(rd_en), .rd_avail(rd_avail), .rd_data(rd_data), .rd_last(rd_last),
        .rd_ovf(rd_ovf), .ovf_clr(ovf_clr), .ovf_flag(ovf_flag), .ovf_irq(ovf_irq)
    );

    int vectors = 0, fails = 0;
    bit done = 0;

    // bench reference model
    logic [7:0] e_d [4096];
    bit e_l [4096];
    bit e_o [4096];
    int m_head = 0, m_tail = 0, m_fs = 0, m_flen = 0, m_st = 0, m_thr = 64;
    bit m_flag = 0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic void mstep(bit sfd, bit v, logic [7:0] d, bit l, bit c, bit r);
        bit ev = 0;
        case (m_st)
            0: if (sfd) begin m_st = 1; m_flen = 0; m_fs = m_tail; end
            1: begin
                if (m_flen < m_thr && (c || r)) begin
                    m_tail = m_fs; m_st = 0;
                end else if (v) begin
                    if (m_tail - m_head == DEPTH) begin
                        ev = 1;
                        if (m_flen >= 64) begin
                            e_l[(m_tail-1) & MSK] = 1;
                            e_o[(m_tail-1) & MSK] = 1;
                        end else m_tail = m_fs;
                        m_st = l ? 0 : 2;
                    end else begin
                        e_d[m_tail & MSK] = d; e_l[m_tail & MSK] = l; e_o[m_tail & MSK] = 0;
                        m_tail++; m_flen++;
                        if (l) begin
                            m_st = 0;
                            if (m_flen < m_thr) m_tail = m_fs;
                        end
                    end
                end
            end
            default: if (v && l) m_st = 0;
        endcase
        if (ev) m_flag = 1;
        else if (ovf_clr) m_flag = 0;
    endfunction

    // drive one cycle at a falling edge, return at the next falling edge
    task automatic cyc(bit sfd, bit v, logic [7:0] d, bit l, bit c, bit r, bit e);
        rx_sfd = sfd; rx_valid = v; rx_data = d; rx_last = l;
        rx_collision = c; rx_reject = r; rx_err = e;
        mstep(sfd, v, d, l, c, r);
        @(negedge clk);
        rx_sfd = 0; rx_valid = 0; rx_last = 0; rx_collision = 0; rx_reject = 0; rx_err = 0;
    endtask

    task automatic set_win(int w);
        cfg_colwin = 8'(w);
        m_thr = (w > 64) ? w : 64;
    endtask

    task automatic frame(int len, int coll_at, int rej_at, int sfd_at, bit err, bit chk_av);
        cyc(1, 0, 8'h00, 0, 0, 0, 0);
        for (int i = 0; i < len; i++) begin
            cyc(i == sfd_at, 1, 8'($urandom), i == len - 1, i == coll_at, i == rej_at,
                err ? 1'b1 : 1'($urandom));
            if (chk_av) begin
                if (i == len - 1) chk(rd_avail == 1, "R2", "avail after end", rd_avail, 1);
                else chk(rd_avail == ((i + 1) >= m_thr), "R2", "avail at byte", rd_avail,
                         int'((i + 1) >= m_thr));
            end
        end
    endtask

    task automatic drain(string req, int exp_cnt);
        int got = 0;
        for (int k = 0; k < 5000; k++) begin
            if (!rd_avail) break;
            chk(m_head != m_tail, req, "extra byte", got, exp_cnt);
            chk(rd_data == e_d[m_head & MSK], req, "data", rd_data, e_d[m_head & MSK]);
            chk(rd_last == e_l[m_head & MSK], "R10", "last flag", rd_last, e_l[m_head & MSK]);
            chk(rd_ovf == e_o[m_head & MSK], "R7", "ovf flag", rd_ovf, e_o[m_head & MSK]);
            m_head++; got++;
            rd_en = 1;
            @(negedge clk);
            rd_en = 0;
        end
        if (exp_cnt >= 0) chk(got == exp_cnt, req, "bytes drained", got, exp_cnt);
        chk(m_head == m_tail, req, "model left", m_tail - m_head, 0);
        m_head = m_tail;
    endtask

    task automatic check_flag(string req);
        chk(ovf_flag == m_flag, req, "ovf_flag", ovf_flag, m_flag);
        chk(ovf_irq == m_flag, "R8", "ovf_irq", ovf_irq, m_flag);
    endtask

    task automatic clear_flag();
        ovf_clr = 1;
        cyc(0, 0, 8'h00, 0, 0, 0, 0);
        ovf_clr = 0;
        chk(ovf_flag == 0, "R8", "flag after clear", ovf_flag, 0);
    endtask

    initial begin
        void'($urandom(32'h1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(rd_avail == 0, "R10", "reset rd_avail", rd_avail, 0);
        chk(ovf_flag == 0, "R10", "reset ovf_flag", ovf_flag, 0);
        chk(ovf_irq == 0, "R10", "reset ovf_irq", ovf_irq, 0);

        // R1: bytes without delimiter are ignored
        for (int i = 0; i < 20; i++) cyc(0, 1, 8'(i), i % 7 == 6, 0, 0, 0);
        chk(rd_avail == 0, "R1", "no frame without sfd", rd_avail, 0);
        drain("R1", 0);

        // R2 / R9: commit timing with errored bytes; R1 sfd inside frame ignored
        set_win(64);  frame(100, -1, -1, 30, 1, 1); drain("R9", 100);
        set_win(90);  frame(95, -1, -1, -1, 0, 1);  drain("R2", 95);

        // R5: runt
        set_win(10); frame(50, -1, -1, -1, 0, 0);
        chk(rd_avail == 0, "R5", "runt hidden", rd_avail, 0); drain("R5", 0);
        set_win(64); frame(63, -1, -1, -1, 0, 0); drain("R5", 0);

        // R3: early and late collision
        frame(100, 30, -1, -1, 0, 0);
        chk(rd_avail == 0, "R3", "early collision", rd_avail, 0); drain("R3", 0);
        frame(100, 80, -1, -1, 0, 0); drain("R3", 100);

        // R4: early and late rejection
        frame(100, -1, 10, -1, 0, 0); drain("R4", 0);
        frame(100, -1, 90, -1, 0, 0); drain("R4", 100);

        // R7: truncation after 64 bytes
        frame(300, -1, -1, -1, 0, 0);
        check_flag("R8"); drain("R7", 256); clear_flag();

        // R6: overflow before 64 bytes, then frame arriving while full
        frame(200, -1, -1, -1, 0, 0);
        frame(100, -1, -1, -1, 0, 0);
        chk(ovf_flag == 1, "R6", "flag after drop", ovf_flag, 1);
        frame(70, -1, -1, -1, 0, 0);
        drain("R6", 200); clear_flag();

        // random rounds
        for (int rnd = 0; rnd < 60; rnd++) begin
            int nf;
            set_win(20 + int'($urandom % 90));
            nf = 1 + int'($urandom % 4);
            for (int f = 0; f < nf; f++) begin
                int len, c, r, s;
                for (int g = 0; g < int'($urandom % 3); g++)
                    cyc(0, 1, 8'($urandom), 1'($urandom), 0, 0, 0);
                len = 30 + int'($urandom % 200);
                c = ($urandom % 4 == 0) ? int'($urandom % len) : -1;
                r = ($urandom % 5 == 0) ? int'($urandom % len) : -1;
                s = ($urandom % 4 == 0) ? int'($urandom % len) : -1;
                frame(len, c, r, s, 0, 0);
                cyc(0, 0, 8'h00, 0, 0, 0, 0);
            end
            check_flag("R8");
            drain("R10", -1);
            if (m_flag) clear_flag();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule